// File: doc/BRIEF.md
# MAC Table Slot Installer

This block installs, updates and removes MAC address entries in a lookup table held in storage outside the block. It accepts one command at a time on a valid/ready handshake. A command carries an operation code, a 48-bit MAC address, a port number or a port mask, and per-operation flags. The block reads the table through a simple read/write port with one cycle of read latency. It scans the table from index 0 upward in a single pass and notes, for each search class, the first index that qualifies. It then builds the new entry, writes it back, and raises a one-cycle completion pulse with a 2-bit status.

On an add, the installer prefers a slot that already holds the same address. Failing that it takes the lowest free slot, and failing that the lowest evictable dynamic unicast slot. A multicast add merges its requested port mask into the mask already stored. A delete either frees the matching slot or rewrites its port mask. The scan stops as soon as an address match is seen, because no later entry can change the outcome.

Table entries are 66+PORTS bits wide:
- bits 47:0 hold the MAC, and bit 40 is its group (multicast) bit;
- bits 61:60 hold the entry kind (0 free, 1 address, 2 VLAN, 3 VLAN-plus-address);
- bits 63:62 hold the unicast class or the multicast forward state;
- bit 64 is the secure flag;
- bit 65 is the blocked flag (unicast) or the super flag (multicast);
- bits 66 upward hold the port number (2 bits, unicast) or the port mask (PORTS bits, multicast).

Top module: `mac_slot_installer`

## Requirements
- R1: `cmd_ready` is high only while the block is idle and no command is in flight. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the cycle after acceptance until `done` has pulsed.
- R2: An entry matches when its kind is 1 or 3 and bits 47:0 equal `cmd_mac`. If any entry matches, the lowest-index match is the target of an add or delete, even when free slots exist at lower indices.
- R3: With no match, an add goes to the lowest-index entry of kind 0.
- R4: With no match and no free entry, an add goes to the lowest-index ageable entry. An entry is ageable when its kind is 1 or 3, bit 40 is 0, and bits 63:62 are 1 or 3 (classes 0 and 2 are never evicted).
- R5: With no match, no free entry and no ageable entry, an add completes with status 2 (no space) and performs no table write.
- R6: A unicast add (`cmd_op`=0) writes a fresh entry: kind 1, MAC, bits 63:62 = 0, bit 64 = `cmd_secure`, bit 65 = `cmd_blocked`, bits 67:66 = `cmd_port`, all other bits 0.
- R7: A multicast add (`cmd_op`=1) starts from the matched entry, or from all zeros without a match. It sets kind 1 and the MAC, sets bit 65 = `cmd_super` and bits 63:62 = `cmd_fwd_state`, and ORs `cmd_mask` into the port mask. All other bits keep their stored values.
- R8: A unicast delete (`cmd_op`=2) of a matching address writes an all-zero entry. Without a match it completes with status 1 (not found) and writes nothing.
- R9: A multicast delete (`cmd_op`=3) with a nonzero `cmd_mask` replaces the stored port mask. With a zero mask it clears the kind bits 61:60 and keeps the rest. Without a match it completes with status 1 and writes nothing.
- R10: `done` is a single-cycle pulse. A status of 0 (ok) follows exactly one table write, made in the cycle just before. Status 3 never appears.
- R11: Once an address match is evaluated at index k, no read of an index above k is issued for that command.
- R12: `tbl_rd` and `tbl_wr` are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 add unicast, 1 add multicast, 2 delete unicast, 3 delete multicast |
| cmd_mac | input | 48 | MAC address of the command |
| cmd_port | input | 2 | Port number for a unicast add |
| cmd_mask | input | PORTS | Port mask for multicast commands |
| cmd_secure | input | 1 | Secure flag for a unicast add |
| cmd_blocked | input | 1 | Blocked flag for a unicast add |
| cmd_super | input | 1 | Super flag for a multicast add |
| cmd_fwd_state | input | 2 | Forward state for a multicast add |
| tbl_rd | output | 1 | Table read request, data valid next cycle |
| tbl_wr | output | 1 | Table write strobe |
| tbl_idx | output | clog2(DEPTH) | Table index for read or write |
| tbl_wdata | output | 66+PORTS | Entry to write |
| tbl_rdata | input | 66+PORTS | Entry read one cycle after `tbl_rd` |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 0 ok, 1 not found, 2 no space |

## Verification
The checker enforces the handshake and protocol rules on every cycle:
- `cmd_ready` falls after acceptance and is low while `done` is high;
- `done` lasts one cycle and never carries status 3;
- an ok completion always follows a write in the previous cycle, and an error completion never does;
- reads and writes never overlap, and neither is active while idle.

Slot choice, entry layout, mask merging and early stopping depend on the table contents. Only the bench scenarios show these: they preload the external table, then compare the slot written, the exact entry bits and the highest index read against values worked out from the requirements.

// File: rtl/slot_inst_pkg.sv
// Package: shared command/status encodings and entry field positions for the
// MAC table slot installer. Assumes entries of 66+PORTS bits.
package slot_inst_pkg;

    typedef enum logic [1:0] {
        OP_ADD_UC = 2'd0,
        OP_ADD_MC = 2'd1,
        OP_DEL_UC = 2'd2,
        OP_DEL_MC = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_NOT_FOUND = 2'd1,
        ST_NO_SPACE  = 2'd2
    } status_e;

    localparam int MAC_W      = 48;
    localparam int F_GROUP    = 40;   // multicast bit inside the MAC
    localparam int F_KIND_LO  = 60;   // 2-bit entry kind
    localparam int F_CLASS_LO = 62;   // unicast class / forward state
    localparam int F_SECURE   = 64;
    localparam int F_FLAG65   = 65;   // blocked (unicast) / super (multicast)
    localparam int F_PORT_LO  = 66;   // port number or port mask
    localparam int PNUM_W     = 2;

    localparam logic [1:0] KIND_FREE = 2'd0;
    localparam logic [1:0] KIND_ADDR = 2'd1;

endpackage

// File: rtl/slot_classify.sv
// slot_classify: purely combinational sort of one table entry into the three
// search classes (address match, free, ageable). Assumes the field layout of
// slot_inst_pkg; the caller qualifies the result with its own valid flag.
module slot_classify
    import slot_inst_pkg::*;
#(
    parameter int EW = 69
) (
    input  logic [EW-1:0]    entry,
    input  logic [MAC_W-1:0] mac,
    output logic             is_match,
    output logic             is_free,
    output logic             is_ageable
);

    logic [1:0] kind;
    logic       addr_kind;

    // Decode the kind and derive the class flags.
    always_comb begin
        kind       = entry[F_KIND_LO +: 2];
        addr_kind  = (kind == 2'd1) || (kind == 2'd3);
        is_free    = (kind == KIND_FREE);
        is_match   = addr_kind && (entry[MAC_W-1:0] == mac);
        // Classes 1 and 3 are the dynamic ones: both have the low class bit set.
        is_ageable = addr_kind && !entry[F_GROUP] && entry[F_CLASS_LO];
    end

endmodule

// File: rtl/entry_build.sv
// entry_build: combinational construction of the entry to be written for
// each operation. Assumes base holds the matched entry when base_hit is set.
module entry_build
    import slot_inst_pkg::*;
#(
    parameter int EW    = 69,
    parameter int PORTS = 3
) (
    input  op_e              op,
    input  logic [MAC_W-1:0] mac,
    input  logic [PNUM_W-1:0] port,
    input  logic [PORTS-1:0] mask,
    input  logic             secure,
    input  logic             blocked,
    input  logic             super_f,
    input  logic [1:0]       fwd_state,
    input  logic [EW-1:0]    base,
    input  logic             base_hit,
    output logic [EW-1:0]    entry
);

    // Assemble the outgoing entry per operation.
    always_comb begin
        entry = '0;
        unique case (op)
            OP_ADD_UC: begin
                entry[MAC_W-1:0]              = mac;
                entry[F_KIND_LO +: 2]         = KIND_ADDR;
                entry[F_SECURE]               = secure;
                entry[F_FLAG65]               = blocked;
                entry[F_PORT_LO +: PNUM_W]    = port;
            end
            OP_ADD_MC: begin
                entry                         = base_hit ? base : '0;
                entry[MAC_W-1:0]              = mac;
                entry[F_KIND_LO +: 2]         = KIND_ADDR;
                entry[F_CLASS_LO +: 2]        = fwd_state;
                entry[F_FLAG65]               = super_f;
                entry[F_PORT_LO +: PORTS]     = (base_hit ? base[F_PORT_LO +: PORTS] : '0) | mask;
            end
            OP_DEL_UC: begin
                entry = '0;
            end
            OP_DEL_MC: begin
                entry = base;
                if (mask != '0) entry[F_PORT_LO +: PORTS] = mask;
                else            entry[F_KIND_LO +: 2]     = KIND_FREE;
            end
            default: entry = '0;
        endcase
    end

endmodule

// File: rtl/mac_slot_installer.sv
// mac_slot_installer: takes one add/delete command, scans the external table
// once in index order (pipelined, one read per cycle, read data one cycle
// later), records the first match / free / ageable index, then writes the
// built entry and pulses done with a status. Assumes the table answers every
// read in the following cycle and accepts a write in the cycle it is strobed.
module mac_slot_installer
    import slot_inst_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PORTS = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = IDX_W + 1,
    localparam int EW    = F_PORT_LO + PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [47:0]      cmd_mac,
    input  logic [1:0]       cmd_port,
    input  logic [PORTS-1:0] cmd_mask,
    input  logic             cmd_secure,
    input  logic             cmd_blocked,
    input  logic             cmd_super,
    input  logic [1:0]       cmd_fwd_state,
    output logic             tbl_rd,
    output logic             tbl_wr,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [EW-1:0]    tbl_wdata,
    input  logic [EW-1:0]    tbl_rdata,
    output logic             done,
    output logic [1:0]       done_status
);

    typedef enum logic [2:0] {S_IDLE, S_SCAN, S_DECIDE, S_WRITE, S_RESP} state_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    state_e             state;
    op_e                c_op;
    logic [MAC_W-1:0]   c_mac;
    logic [PNUM_W-1:0]  c_port;
    logic [PORTS-1:0]   c_mask;
    logic               c_secure, c_blocked, c_super;
    logic [1:0]         c_fwd;

    logic [CNT_W-1:0]   rd_cnt;
    logic               ev_vld;
    logic [IDX_W-1:0]   ev_idx;
    logic               m_hit, f_hit, a_hit;
    logic [IDX_W-1:0]   m_idx, f_idx, a_idx;
    logic [EW-1:0]      m_entry;
    logic [IDX_W-1:0]   wr_idx;
    logic [EW-1:0]      wr_data;
    status_e            status;

    logic               cls_match, cls_free, cls_age;
    logic [EW-1:0]      built;
    logic               is_add;

    slot_classify #(.EW(EW)) u_classify (
        .entry      (tbl_rdata),
        .mac        (c_mac),
        .is_match   (cls_match),
        .is_free    (cls_free),
        .is_ageable (cls_age)
    );

    entry_build #(.EW(EW), .PORTS(PORTS)) u_build (
        .op        (c_op),
        .mac       (c_mac),
        .port      (c_port),
        .mask      (c_mask),
        .secure    (c_secure),
        .blocked   (c_blocked),
        .super_f   (c_super),
        .fwd_state (c_fwd),
        .base      (m_entry),
        .base_hit  (m_hit),
        .entry     (built)
    );

    // Table port and handshake outputs decoded from the state.
    always_comb begin
        is_add      = (c_op == OP_ADD_UC) || (c_op == OP_ADD_MC);
        cmd_ready   = (state == S_IDLE);
        tbl_rd      = (state == S_SCAN) && (rd_cnt < CNT_W'(DEPTH)) && !(ev_vld && cls_match);
        tbl_wr      = (state == S_WRITE);
        tbl_idx     = (state == S_SCAN) ? rd_cnt[IDX_W-1:0] : wr_idx;
        tbl_wdata   = wr_data;
        done        = (state == S_RESP);
        done_status = status;
    end

    // Sequencer: accept, scan with first-hit capture, decide, write, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            c_op      <= OP_ADD_UC;
            c_mac     <= '0;
            c_port    <= '0;
            c_mask    <= '0;
            c_secure  <= 1'b0;
            c_blocked <= 1'b0;
            c_super   <= 1'b0;
            c_fwd     <= '0;
            rd_cnt    <= '0;
            ev_vld    <= 1'b0;
            ev_idx    <= '0;
            m_hit     <= 1'b0;
            f_hit     <= 1'b0;
            a_hit     <= 1'b0;
            m_idx     <= '0;
            f_idx     <= '0;
            a_idx     <= '0;
            m_entry   <= '0;
            wr_idx    <= '0;
            wr_data   <= '0;
            status    <= ST_OK;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        c_op      <= op_e'(cmd_op);
                        c_mac     <= cmd_mac;
                        c_port    <= cmd_port;
                        c_mask    <= cmd_mask;
                        c_secure  <= cmd_secure;
                        c_blocked <= cmd_blocked;
                        c_super   <= cmd_super;
                        c_fwd     <= cmd_fwd_state;
                        rd_cnt    <= '0;
                        ev_vld    <= 1'b0;
                        m_hit     <= 1'b0;
                        f_hit     <= 1'b0;
                        a_hit     <= 1'b0;
                        state     <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (tbl_rd) rd_cnt <= rd_cnt + 1'b1;
                    ev_vld <= tbl_rd;
                    ev_idx <= rd_cnt[IDX_W-1:0];
                    if (ev_vld) begin
                        if (cls_free && !f_hit) begin
                            f_hit <= 1'b1;
                            f_idx <= ev_idx;
                        end
                        if (cls_age && !a_hit) begin
                            a_hit <= 1'b1;
                            a_idx <= ev_idx;
                        end
                        if (cls_match) begin
                            m_hit   <= 1'b1;
                            m_idx   <= ev_idx;
                            m_entry <= tbl_rdata;
                            state   <= S_DECIDE;
                        end else if (ev_idx == LAST_IDX) begin
                            state   <= S_DECIDE;
                        end
                    end
                end
                S_DECIDE: begin
                    wr_data <= built;
                    if (m_hit) begin
                        wr_idx <= m_idx;
                        state  <= S_WRITE;
                    end else if (is_add && f_hit) begin
                        wr_idx <= f_idx;
                        state  <= S_WRITE;
                    end else if (is_add && a_hit) begin
                        wr_idx <= a_idx;
                        state  <= S_WRITE;
                    end else begin
                        status <= is_add ? ST_NO_SPACE : ST_NOT_FOUND;
                        state  <= S_RESP;
                    end
                end
                S_WRITE: begin
                    status <= ST_OK;
                    state  <= S_RESP;
                end
                S_RESP: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/slot_installer_chk.sv
// slot_installer_chk: protocol checker for mac_slot_installer, watching only
// its ports. Assumes synchronous active-low reset.
module slot_installer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       tbl_rd,
    input logic       tbl_wr,
    input logic       done,
    input logic [1:0] done_status
);

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R1

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_status != 2'd3)); // R10

    AST_OK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == 2'd0) |-> $past(tbl_wr)); // R10

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status != 2'd0) |-> !$past(tbl_wr)); // R5

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbl_rd && tbl_wr)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!tbl_rd && !tbl_wr)); // R12

endmodule

bind mac_slot_installer slot_installer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .tbl_rd      (tbl_rd),
    .tbl_wr      (tbl_wr),
    .done        (done),
    .done_status (done_status)
);

// File: tb/mac_slot_installer_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outcome of each command,
// the monitor pops it on done and compares status, write count and scan span.
module mac_slot_installer_bench;

    localparam int DEPTH = 16;
    localparam int PORTS = 3;
    localparam int IDX_W = 4;
    localparam int EW    = 69;

    typedef struct {
        logic [1:0] status;
        int         writes;
        int         max_rd;   // -1: do not check
        string      req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [1:0]       cmd_op = '0;
    logic [47:0]      cmd_mac = '0;
    logic [1:0]       cmd_port = '0;
    logic [PORTS-1:0] cmd_mask = '0;
    logic             cmd_secure = 1'b0;
    logic             cmd_blocked = 1'b0;
    logic             cmd_super = 1'b0;
    logic [1:0]       cmd_fwd_state = '0;
    logic             tbl_rd, tbl_wr;
    logic [IDX_W-1:0] tbl_idx;
    logic [EW-1:0]    tbl_wdata;
    logic [EW-1:0]    tbl_rdata = '0;
    logic             done;
    logic [1:0]       done_status;

    logic [EW-1:0]    mem [DEPTH];
    exp_t             exp_q[$];
    int               checks = 0;
    int               fails = 0;
    int               wr_seen = 0;
    int               max_rd = -1;
    logic             done_prev = 1'b0;
    bit               finished = 1'b0;

    always #2.5 clk = ~clk;

    mac_slot_installer #(.DEPTH(DEPTH), .PORTS(PORTS)) u_mac_slot_installer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_mac(cmd_mac), .cmd_port(cmd_port), .cmd_mask(cmd_mask),
        .cmd_secure(cmd_secure), .cmd_blocked(cmd_blocked), .cmd_super(cmd_super),
        .cmd_fwd_state(cmd_fwd_state), .tbl_rd(tbl_rd), .tbl_wr(tbl_wr),
        .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .done(done), .done_status(done_status)
    );

    // External table model: one-cycle read latency, write on strobe.
    always @(posedge clk) begin
        if (tbl_rd) tbl_rdata <= mem[tbl_idx];
        if (tbl_wr) mem[tbl_idx] <= tbl_wdata;
    end

    function automatic logic [EW-1:0] ent(input logic [1:0] kind, input logic [47:0] mac,
                                          input logic [1:0] cls, input logic b64,
                                          input logic b65, input logic [2:0] top);
        return {top, b65, b64, cls, kind, 12'h000, mac};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [EW-1:0] act, input logic [EW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic fill_static();
        for (int i = 0; i < DEPTH; i++)
            mem[i] = ent(2'd1, 48'h02_00_00_00_10_00 + 48'(i), 2'd0, 1'b0, 1'b0, 3'b000);
    endtask

    // Monitor: protocol checks and scoreboard pop on done.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (tbl_rd && tbl_wr)
                check(1'b0, "R12", "read and write together", 1, 0);
            if (cmd_ready && (tbl_rd || tbl_wr))
                check(1'b0, "R12", "table access while idle", 1, 0);
            if (tbl_wr) wr_seen++;
            if (tbl_rd && int'(tbl_idx) > max_rd) max_rd = int'(tbl_idx);
            if (done && done_prev)
                check(1'b0, "R10", "done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(done_status == e.status, e.req, "status", done_status, e.status);
                    check(wr_seen == e.writes, "R10", "write count", wr_seen, e.writes);
                    if (e.max_rd >= 0)
                        check(max_rd == e.max_rd, "R11", "highest read index", max_rd, e.max_rd);
                end
                wr_seen = 0;
                max_rd  = -1;
            end
            done_prev = done;
        end
    end

    // Driver: push expectation, present command, wait for its completion.
    task automatic issue(input logic [1:0] op, input logic [47:0] mac, input logic [1:0] port,
                         input logic [2:0] mask, input logic sec, input logic blk,
                         input logic sup, input logic [1:0] fwd,
                         input logic [1:0] st, input int wr, input int mrd, input string req);
        exp_t e;
        e.status = st; e.writes = wr; e.max_rd = mrd; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_op = op; cmd_mac = mac; cmd_port = port; cmd_mask = mask;
        cmd_secure = sec; cmd_blocked = blk; cmd_super = sup; cmd_fwd_state = fwd;
        cmd_valid = 1'b1;
        check(cmd_ready == 1'b1, "R1", "ready before command", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_B = 48'h02_aa_bb_cc_dd_ee;
    localparam logic [47:0] MAC_C = 48'h02_77_00_00_00_07;
    localparam logic [47:0] MAC_M = 48'h01_00_5e_00_00_01;
    localparam logic [47:0] MAC_N = 48'h01_00_5e_00_00_09;

    initial begin
        logic [EW-1:0] snap [DEPTH];
        int diff;
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R12: reset state
        check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        check(done == 1'b0, "R10", "done after reset", done, 0);
        check(!tbl_rd && !tbl_wr, "R12", "table idle after reset", {tbl_rd, tbl_wr}, 0);

        // R3 R6: unicast add into an empty table lands at index 0
        clear_mem();
        issue(2'd0, MAC_A, 2'd2, 3'b000, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1, -1, "R3");
        check(mem[0] == ent(2'd1, MAC_A, 2'd0, 1'b1, 1'b0, 3'b010), "R6", "unicast entry", mem[0],
              ent(2'd1, MAC_A, 2'd0, 1'b1, 1'b0, 3'b010));
        check(mem[1] == '0, "R3", "next slot untouched", mem[1], '0);

        // R2 R11: existing match beats a lower free slot, first match wins
        clear_mem();
        mem[0] = ent(2'd1, MAC_C, 2'd0, 1'b0, 1'b0, 3'b000);
        mem[1] = ent(2'd1, MAC_B, 2'd0, 1'b0, 1'b0, 3'b000);
        mem[5] = ent(2'd3, MAC_A, 2'd1, 1'b0, 1'b0, 3'b001);
        mem[9] = ent(2'd1, MAC_A, 2'd0, 1'b0, 1'b0, 3'b000);
        issue(2'd0, MAC_A, 2'd3, 3'b000, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1, 5, "R2");
        check(mem[5] == ent(2'd1, MAC_A, 2'd0, 1'b0, 1'b1, 3'b011), "R2", "matched slot rewritten",
              mem[5], ent(2'd1, MAC_A, 2'd0, 1'b0, 1'b1, 3'b011));
        check(mem[2] == '0, "R2", "free slot left alone", mem[2], '0);
        check(mem[9] == ent(2'd1, MAC_A, 2'd0, 1'b0, 1'b0, 3'b000), "R2", "later duplicate kept",
              mem[9], ent(2'd1, MAC_A, 2'd0, 1'b0, 1'b0, 3'b000));

        // R4: full table, lowest ageable dynamic unicast is evicted
        fill_static();
        mem[3] = ent(2'd1, MAC_C, 2'd2, 1'b0, 1'b0, 3'b000);
        mem[4] = ent(2'd1, MAC_N, 2'd3, 1'b0, 1'b0, 3'b001);
        mem[7] = ent(2'd3, 48'h02_00_00_00_20_07, 2'd1, 1'b0, 1'b0, 3'b001);
        mem[9] = ent(2'd1, 48'h02_00_00_00_20_09, 2'd3, 1'b0, 1'b0, 3'b000);
        issue(2'd0, MAC_B, 2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1, -1, "R4");
        check(mem[7] == ent(2'd1, MAC_B, 2'd0, 1'b0, 1'b0, 3'b001), "R4", "evicted slot 7",
              mem[7], ent(2'd1, MAC_B, 2'd0, 1'b0, 1'b0, 3'b001));
        check(mem[9] == ent(2'd1, 48'h02_00_00_00_20_09, 2'd3, 1'b0, 1'b0, 3'b000), "R4",
              "second ageable kept", mem[9], ent(2'd1, 48'h02_00_00_00_20_09, 2'd3, 1'b0, 1'b0, 3'b000));

        // R5: full table of static entries gives no space and no change
        fill_static();
        for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
        issue(2'd1, MAC_M, 2'd0, 3'b011, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 0, -1, "R5");
        diff = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != snap[i]) diff++;
        check(diff == 0, "R5", "table unchanged entries", diff, 0);

        // R7: multicast add merges with the stored mask, keeps bit 64
        clear_mem();
        mem[6] = ent(2'd1, MAC_M, 2'd0, 1'b1, 1'b0, 3'b001);
        issue(2'd1, MAC_M, 2'd0, 3'b100, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0, 1, 6, "R7");
        check(mem[6] == ent(2'd1, MAC_M, 2'd3, 1'b1, 1'b1, 3'b101), "R7", "merged multicast",
              mem[6], ent(2'd1, MAC_M, 2'd3, 1'b1, 1'b1, 3'b101));
        // R7: new multicast entry from zero
        issue(2'd1, MAC_N, 2'd0, 3'b010, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1, -1, "R7");
        check(mem[0] == ent(2'd1, MAC_N, 2'd1, 1'b0, 1'b0, 3'b010), "R7", "fresh multicast",
              mem[0], ent(2'd1, MAC_N, 2'd1, 1'b0, 1'b0, 3'b010));

        // R8: unicast delete, then not found on repeat
        clear_mem();
        mem[0] = ent(2'd1, MAC_C, 2'd0, 1'b0, 1'b0, 3'b000);
        mem[3] = ent(2'd1, MAC_A, 2'd0, 1'b1, 1'b1, 3'b001);
        issue(2'd2, MAC_A, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1, 3, "R8");
        check(mem[3] == '0, "R8", "deleted entry zero", mem[3], '0);
        issue(2'd2, MAC_A, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 0, -1, "R8");
        check(mem[0] == ent(2'd1, MAC_C, 2'd0, 1'b0, 1'b0, 3'b000), "R8", "other entry kept",
              mem[0], ent(2'd1, MAC_C, 2'd0, 1'b0, 1'b0, 3'b000));

        // R9: multicast delete replaces mask, zero mask frees, then not found
        clear_mem();
        mem[15] = ent(2'd1, MAC_M, 2'd3, 1'b1, 1'b1, 3'b111);
        issue(2'd3, MAC_M, 2'd0, 3'b010, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1, 15, "R9");
        check(mem[15] == ent(2'd1, MAC_M, 2'd3, 1'b1, 1'b1, 3'b010), "R9", "mask replaced",
              mem[15], ent(2'd1, MAC_M, 2'd3, 1'b1, 1'b1, 3'b010));
        issue(2'd3, MAC_M, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1, 15, "R9");
        check(mem[15] == ent(2'd0, MAC_M, 2'd3, 1'b1, 1'b1, 3'b010), "R9", "kind cleared",
              mem[15], ent(2'd0, MAC_M, 2'd3, 1'b1, 1'b1, 3'b010));
        issue(2'd3, MAC_M, 2'd0, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 0, -1, "R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R10 watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule